// File: doc/BRIEF.md
# Hidden Address Window Read Filter

This block sits on the request and read-return paths of several host memory apertures. Software programs one address window with two configuration registers, a start bound and an end bound, and arms it with a single enable bit. While the filter is armed, any read whose offset inside its own aperture falls in the window returns all-zero data. Reads outside the window, and every write, pass through unchanged.

The comparison uses each aperture's own offset, not the memory address that the aperture later translates it to. One window therefore covers different physical words in each aperture. Requests go straight through to the memory side. Read data comes back from memory one cycle after the request, and the filter masks it on the way to the requester.

A build parameter selects an inert variant. In that variant the registers still read and write normally, but no read is ever zeroed.

Top module: `hidewin_filter`

## Requirements
- R1: After reset the enable bit is clear and both bounds are zero, so both registers read back 0 and every read returns memory data.
- R2: Writing the start register (`cfg_sel` = 0) stores the enable from data bit 31 and the start word from bits 28:2. Read-back shows only those bits, and bits 30:29 and 1:0 read 0. The register holds its value when no write is made.
- R3: Writing the end register (`cfg_sel` = 1) stores the end word from bits 28:2 and leaves the enable bit and the start bound unchanged. All other bits read 0.
- R4: A read request on a port produces `ap_rvalid` exactly one cycle later. If the filter is enabled and the offset word (offset bits 28:2) lies between the start and end words, both bounds included, `ap_rdata` is 0.
- R5: A read outside the window returns the memory's data unchanged, one cycle after the request.
- R6: Offset bits 1:0 take no part in the match. With a word-aligned start S and end E, offset S-1 is not hidden and offset E+1 is hidden.
- R7: Writes, including writes inside an armed window, reach the memory side with their offset and data unchanged and produce no `ap_rvalid`.
- R8: When the start word is greater than the end word, no offset matches.
- R9: When the enable bit is 0, no read is zeroed, whatever the bounds.
- R10: With `HIDE_IMPL` = 0 the registers behave as in R2 and R3, but no read is ever zeroed.
- R11: Each port is matched on its own offset, independently and concurrently. A physical word that is hidden through one aperture stays readable through another aperture whose offset for it lies outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Register select: 0 start/enable, 1 end |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register (combinational) |
| ap_req_valid | input | NUM_PORTS | Per-aperture request valid |
| ap_req_write | input | NUM_PORTS | Per-aperture request is a write |
| ap_req_offset | input | NUM_PORTS x 29 | Per-aperture byte offset |
| ap_req_wdata | input | NUM_PORTS x DATA_W | Per-aperture write data |
| mem_req_valid | output | NUM_PORTS | Request valid toward memory |
| mem_req_write | output | NUM_PORTS | Request write flag toward memory |
| mem_req_offset | output | NUM_PORTS x 29 | Offset toward memory |
| mem_req_wdata | output | NUM_PORTS x DATA_W | Write data toward memory |
| mem_rdata | input | NUM_PORTS x DATA_W | Memory read data, one cycle after the request |
| ap_rvalid | output | NUM_PORTS | Read data valid toward each requester |
| ap_rdata | output | NUM_PORTS x DATA_W | Filtered read data toward each requester |

## Verification
Two things can happen in the same cycle: reads on all apertures at once, and a read inside the window on one aperture next to a pass-through read on another. The bench issues simultaneous reads in which one aperture hits the window and another reaches the same physical word through an offset outside the window. It expects zero on the first and the memory's data on the second. An inert instance receives identical stimulus, and every read it returns is judged against memory data, while the armed instance's result for the same read is judged against the window rules.

// File: rtl/hidewin_pkg.sv
// Shared constants and types for the hidden address window read filter.
// Assumes 32-bit configuration registers and 29-bit aperture offsets.
package hidewin_pkg;
    localparam int REG_W    = 32;
    localparam int OFFS_W   = 29;
    localparam int WORD_LSB = 2;
    localparam int WORD_W   = OFFS_W - WORD_LSB;
    localparam int EN_BIT   = 31;

    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } hw_sel_e;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] lo_w;
        logic [WORD_W-1:0] hi_w;
    } hw_cfg_t;

    // Word index of a byte offset; the two byte-select bits are dropped.
    function automatic logic [WORD_W-1:0] word_of(input logic [OFFS_W-1:0] off);
        return off[OFFS_W-1:WORD_LSB];
    endfunction
endpackage

// File: rtl/hidewin_regs.sv
// Window configuration registers: start word plus enable, and end word.
// Assumes one write per cycle, selected by cfg_sel; read-back is combinational.
module hidewin_regs
    import hidewin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output hw_cfg_t          cfg_o
);
    hw_cfg_t cfg_q;
    hw_sel_e sel;

    assign sel   = hw_sel_e'(cfg_sel);
    assign cfg_o = cfg_q;

    // Capture register writes; the end register never touches enable or start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            if (sel == SEL_LOW) begin
                cfg_q.en   <= cfg_wdata[EN_BIT];
                cfg_q.lo_w <= cfg_wdata[OFFS_W-1:WORD_LSB];
            end else begin
                cfg_q.hi_w <= cfg_wdata[OFFS_W-1:WORD_LSB];
            end
        end
    end

    // Rebuild the selected register image with unused bits at zero.
    always_comb begin
        cfg_rdata = '0;
        if (sel == SEL_LOW) begin
            cfg_rdata[EN_BIT]                = cfg_q.en;
            cfg_rdata[OFFS_W-1:WORD_LSB]     = cfg_q.lo_w;
        end else begin
            cfg_rdata[OFFS_W-1:WORD_LSB]     = cfg_q.hi_w;
        end
    end

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q)); // R2
    AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> ($stable(cfg_q.en) && $stable(cfg_q.lo_w))); // R3
    AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> $stable(cfg_q.hi_w)); // R2
endmodule

// File: rtl/hidewin_cmp.sv
// Per-aperture window comparator. Matches the offset word against the
// inclusive [start, end] range. With HIDE_IMPL = 0 it never matches.
// Assumes cfg is stable for the cycle in which a request is presented.
module hidewin_cmp
    import hidewin_pkg::*;
#(
    parameter bit HIDE_IMPL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hw_cfg_t           cfg,
    input  logic [OFFS_W-1:0] offset,
    output logic              hit
);
    logic [WORD_W-1:0] word;

    assign word = word_of(offset);

    generate
        if (HIDE_IMPL) begin : g_live
            logic above_lo;
            logic below_hi;
            // Both bounds inclusive; an inverted range matches nothing.
            always_comb begin
                above_lo = (word >= cfg.lo_w);
                below_hi = (word <= cfg.hi_w);
                hit      = cfg.en && above_lo && below_hi;
            end
        end else begin : g_inert
            // Registers remain programmable but the window has no effect.
            always_comb begin
                hit = 1'b0;
            end
        end
    endgenerate

    AST_INVERTED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.lo_w > cfg.hi_w) |-> !hit); // R8
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !hit); // R9
endmodule

// File: rtl/hidewin_lane.sv
// Per-aperture read-return lane. Records whether a read hit the window and
// masks the memory data that arrives one cycle later.
// Assumes memory returns read data exactly one cycle after the request.
module hidewin_lane #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              hit,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    logic rd_q;
    logic hide_q;

    // Remember each read and whether its data must be hidden.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            hide_q <= 1'b0;
        end else begin
            rd_q   <= req_valid && !req_write;
            hide_q <= req_valid && !req_write && hit;
        end
    end

    // Zero the returning data for a hidden read, pass it otherwise.
    always_comb begin
        rvalid = rd_q;
        rdata  = hide_q ? '0 : mem_rdata;
    end

    AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req_valid && !req_write)); // R4
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rvalid); // R7
    AST_HIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && $past(hit)) |-> (rdata == '0)); // R4
    AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !$past(hit)) |-> (rdata == mem_rdata)); // R5
endmodule

// File: rtl/hidewin_filter.sv
// Top of the hidden address window read filter. Requests pass straight to
// memory; each aperture gets its own comparator and read-return lane.
// Assumes memory read latency of one cycle on every aperture.
module hidewin_filter
    import hidewin_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int DATA_W    = 32,
    parameter bit HIDE_IMPL = 1'b1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic                               cfg_sel,
    input  logic [31:0]                        cfg_wdata,
    output logic [31:0]                        cfg_rdata,
    input  logic [NUM_PORTS-1:0]               ap_req_valid,
    input  logic [NUM_PORTS-1:0]               ap_req_write,
    input  logic [NUM_PORTS-1:0][28:0]         ap_req_offset,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]   ap_req_wdata,
    output logic [NUM_PORTS-1:0]               mem_req_valid,
    output logic [NUM_PORTS-1:0]               mem_req_write,
    output logic [NUM_PORTS-1:0][28:0]         mem_req_offset,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   mem_req_wdata,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]   mem_rdata,
    output logic [NUM_PORTS-1:0]               ap_rvalid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   ap_rdata
);
    hw_cfg_t              cfg;
    logic [NUM_PORTS-1:0] hit;

    hidewin_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_o     (cfg)
    );

    // Requests, including all writes, reach memory untouched.
    always_comb begin
        mem_req_valid  = ap_req_valid;
        mem_req_write  = ap_req_write;
        mem_req_offset = ap_req_offset;
        mem_req_wdata  = ap_req_wdata;
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            hidewin_cmp #(
                .HIDE_IMPL (HIDE_IMPL)
            ) u_cmp (
                .clk    (clk),
                .rst_n  (rst_n),
                .cfg    (cfg),
                .offset (ap_req_offset[p]),
                .hit    (hit[p])
            );

            hidewin_lane #(
                .DATA_W (DATA_W)
            ) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_valid (ap_req_valid[p]),
                .req_write (ap_req_write[p]),
                .hit       (hit[p]),
                .mem_rdata (mem_rdata[p]),
                .rvalid    (ap_rvalid[p]),
                .rdata     (ap_rdata[p])
            );

            if (!HIDE_IMPL) begin : g_inert_chk
                AST_INERT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                    ap_rvalid[p] |-> (ap_rdata[p] == mem_rdata[p])); // R10
            end
        end
    endgenerate
endmodule

// File: tb/hidewin_filter_bench.sv
module hidewin_filter_bench;
    localparam int NP = 3;
    localparam int DW = 32;
    localparam int MEM_WORDS = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                   cfg_we = 1'b0;
    logic                   cfg_sel = 1'b0;
    logic [31:0]            cfg_wdata = '0;
    logic [31:0]            cfg_rdata, cfg_rdata_i;
    logic [NP-1:0]          ap_req_valid = '0;
    logic [NP-1:0]          ap_req_write = '0;
    logic [NP-1:0][28:0]    ap_req_offset = '0;
    logic [NP-1:0][DW-1:0]  ap_req_wdata = '0;
    logic [NP-1:0]          mem_req_valid, mem_req_write;
    logic [NP-1:0][28:0]    mem_req_offset;
    logic [NP-1:0][DW-1:0]  mem_req_wdata;
    logic [NP-1:0]          mv_i, mw_i;
    logic [NP-1:0][28:0]    mo_i;
    logic [NP-1:0][DW-1:0]  md_i;
    logic [NP-1:0][DW-1:0]  mem_rdata = '0;
    logic [NP-1:0]          ap_rvalid, ap_rvalid_i;
    logic [NP-1:0][DW-1:0]  ap_rdata, ap_rdata_i;

    logic [31:0] mem [MEM_WORDS];
    int n_chk = 0;
    int n_bad = 0;

    hidewin_filter #(.NUM_PORTS(NP), .DATA_W(DW), .HIDE_IMPL(1'b1)) u_hidewin_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ap_req_valid(ap_req_valid), .ap_req_write(ap_req_write),
        .ap_req_offset(ap_req_offset), .ap_req_wdata(ap_req_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_offset(mem_req_offset), .mem_req_wdata(mem_req_wdata),
        .mem_rdata(mem_rdata), .ap_rvalid(ap_rvalid), .ap_rdata(ap_rdata)
    );

    hidewin_filter #(.NUM_PORTS(NP), .DATA_W(DW), .HIDE_IMPL(1'b0)) u_hidewin_filter_inert (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_i),
        .ap_req_valid(ap_req_valid), .ap_req_write(ap_req_write),
        .ap_req_offset(ap_req_offset), .ap_req_wdata(ap_req_wdata),
        .mem_req_valid(mv_i), .mem_req_write(mw_i),
        .mem_req_offset(mo_i), .mem_req_wdata(md_i),
        .mem_rdata(mem_rdata), .ap_rvalid(ap_rvalid_i), .ap_rdata(ap_rdata_i)
    );

    // Each aperture maps its offset onto memory at a different word base.
    function automatic int phys(input int p, input logic [28:0] off);
        return (p * 32 + int'(off[9:2])) % MEM_WORDS;
    endfunction

    // Memory model with one cycle read latency, driven by the armed instance.
    initial begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'hA500_0000 | (i * 32'h0001_0101) | 32'h1;
    end
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (mem_req_valid[p] && mem_req_write[p])
                mem[phys(p, mem_req_offset[p])] <= mem_req_wdata[p];
            else if (mem_req_valid[p])
                mem_rdata[p] <= mem[phys(p, mem_req_offset[p])];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic sel, output logic [31:0] d, output logic [31:0] di);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        d = cfg_rdata; di = cfg_rdata_i;
    endtask

    task automatic do_read(input int p, input logic [28:0] off, output logic [31:0] d,
                           output logic v, output logic [31:0] di);
        @(negedge clk);
        ap_req_valid[p] = 1'b1; ap_req_write[p] = 1'b0; ap_req_offset[p] = off;
        @(negedge clk);
        d = ap_rdata[p]; v = ap_rvalid[p]; di = ap_rdata_i[p];
        ap_req_valid[p] = 1'b0;
    endtask

    task automatic do_write(input int p, input logic [28:0] off, input logic [31:0] w);
        @(negedge clk);
        ap_req_valid[p] = 1'b1; ap_req_write[p] = 1'b1; ap_req_offset[p] = off; ap_req_wdata[p] = w;
        @(negedge clk);
        chk("R7 no rvalid on write", {31'b0, ap_rvalid[p]}, 32'h0);
        ap_req_valid[p] = 1'b0; ap_req_write[p] = 1'b0;
    endtask

    // Reset state: registers zero, reads pass memory data.
    task automatic t_reset();
        logic [31:0] d, di, e;
        logic v;
        cfg_read(1'b0, d, di); chk("R1 start reg", d, 32'h0);
        cfg_read(1'b1, d, di); chk("R1 end reg", d, 32'h0);
        e = mem[phys(0, 29'h0)];
        do_read(0, 29'h0, d, v, di); chk("R1 read passes", d, e);
    endtask

    // Register field layout and independence.
    task automatic t_regs();
        logic [31:0] d, di;
        cfg_write(1'b0, 32'hFFFF_FFFF);
        cfg_write(1'b1, 32'h0000_0000);
        cfg_read(1'b0, d, di); chk("R2 start readback", d, 32'h9FFF_FFFC);
        chk("R10 inert start readback", di, 32'h9FFF_FFFC);
        cfg_write(1'b1, 32'hFFFF_FFFF);
        cfg_read(1'b1, d, di); chk("R3 end readback", d, 32'h1FFF_FFFC);
        chk("R10 inert end readback", di, 32'h1FFF_FFFC);
        cfg_read(1'b0, d, di); chk("R3 end write keeps start", d, 32'h9FFF_FFFC);
        cfg_write(1'b0, 32'h0000_0000);
        cfg_read(1'b1, d, di); chk("R2 start write keeps end", d, 32'h1FFF_FFFC);
    endtask

    // Writes inside an armed window reach memory.
    task automatic t_writes();
        cfg_write(1'b0, 32'h8000_0100);
        cfg_write(1'b1, 32'h0000_013C);
        for (int p = 0; p < NP; p++) begin
            do_write(p, 29'h110, 32'hC0DE_0000 | p);
            @(negedge clk);
            chk("R7 write lands in memory", mem[phys(p, 29'h110)], 32'hC0DE_0000 | p);
        end
    endtask

    // Boundary reads on every aperture with window 0x100..0x13C.
    task automatic t_bounds();
        logic [28:0] offs [6];
        logic        hid  [6];
        logic [31:0] d, di, e;
        logic v;
        offs[0] = 29'h0FC; hid[0] = 1'b0;
        offs[1] = 29'h0FF; hid[1] = 1'b0;
        offs[2] = 29'h100; hid[2] = 1'b1;
        offs[3] = 29'h13C; hid[3] = 1'b1;
        offs[4] = 29'h13D; hid[4] = 1'b1;
        offs[5] = 29'h140; hid[5] = 1'b0;
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 6; k++) begin
                e = mem[phys(p, offs[k])];
                do_read(p, offs[k], d, v, di);
                chk("R4 rvalid after read", {31'b0, v}, 32'h1);
                if (k == 1 || k == 4) chk("R6 byte bits ignored", d, hid[k] ? 32'h0 : e);
                else if (hid[k])      chk("R4 hidden read zero", d, 32'h0);
                else                  chk("R5 outside read passes", d, e);
                chk("R10 inert never hides", di, e);
            end
        end
    endtask

    // Concurrent reads; same physical word seen through two apertures.
    task automatic t_concurrent();
        logic [31:0] e0, e1, e2;
        e0 = mem[phys(0, 29'h120)];
        e1 = mem[phys(1, 29'h0A0)];
        e2 = mem[phys(2, 29'h13C)];
        @(negedge clk);
        ap_req_valid = '1; ap_req_write = '0;
        ap_req_offset[0] = 29'h120; ap_req_offset[1] = 29'h0A0; ap_req_offset[2] = 29'h13C;
        @(negedge clk);
        chk("R11 port0 hidden", ap_rdata[0], 32'h0);
        chk("R11 port1 same phys word visible", ap_rdata[1], e1);
        chk("R11 port1 phys matches port0", e1, e0);
        chk("R11 port2 hidden", ap_rdata[2], 32'h0);
        chk("R11 all valid", {29'b0, ap_rvalid}, 32'h7);
        ap_req_valid = '0;
        if (e2 == 32'h0) chk("R11 data nonzero", e2, 32'h1);
    endtask

    // Inverted bounds and disable both stop matching.
    task automatic t_inverted_and_off();
        logic [31:0] d, di, e;
        logic v;
        cfg_write(1'b0, 32'h8000_0140);
        cfg_write(1'b1, 32'h0000_0100);
        e = mem[phys(1, 29'h120)];
        do_read(1, 29'h120, d, v, di); chk("R8 inverted window no match", d, e);
        e = mem[phys(1, 29'h140)];
        do_read(1, 29'h140, d, v, di); chk("R8 inverted at start bound", d, e);
        cfg_write(1'b0, 32'h0000_0100);
        cfg_write(1'b1, 32'h0000_013C);
        e = mem[phys(2, 29'h120)];
        do_read(2, 29'h120, d, v, di); chk("R9 disabled no match", d, e);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_writes();
        t_bounds();
        t_concurrent();
        t_inverted_and_off();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule